// File: doc/BRIEF.md
# Strobed-Start Acknowledged Bus Slave

This block is a clocked target on a 32-bit shared data bus that uses a one-cycle, active-low start strobe and an active-low acknowledge. A master presents a byte address, a direction bit and a two-bit size code in the same cycle as the strobe. When the address falls inside the slave's window, the slave captures the request at that edge and waits a fixed number of cycles, set separately for reads and for writes. It then pulls acknowledge low for exactly one cycle. The master holds address, direction and write data steady until it sees acknowledge. Write data is taken at the acknowledge edge, and read data is on the bus during the acknowledge cycle.

The bus carries no byte enables. The slave works out the active byte lanes and checks alignment itself from the low address bits and the size code. Lanes are numbered big-endian: byte offset 0 sits in the most significant byte of the data word. A small on-chip word array holds the data. A request in the window that is misaligned, or that uses the reserved size code, is still acknowledged. It leaves memory unchanged, returns zero data and sets a sticky error flag.

Top module: `strobe_ack_slave`

## Requirements
- R1: Address, direction and size are sampled only at the edge where `ts_n_i` is low. Changes on those inputs during the wait cycles do not alter the transfer in progress.
- R2: A start whose address bits [25:8] differ from the window base (default byte address 0x1000, 64 words) gets no acknowledge and writes nothing.
- R3: Acknowledge is low for exactly one cycle, never in the start cycle. It falls RD_WAIT cycles after the first cycle following the start edge for reads, and WR_WAIT cycles after it for writes (zero waits gives a two-cycle transfer).
- R4: Size code `tsiz_i` is 2'b01 for a byte (any offset), 2'b10 for a half-word (offset bit 0 must be 0) and 2'b00 for a word (offset bits 1:0 must be 0). Code 2'b11 is treated as misaligned.
- R5: Byte offset k (address bits [1:0], where `addr_i[0]` is the least significant address bit) maps to data bits [31-8k:24-8k].
- R6: A write updates only the lanes its offset and size cover, using `data_i` as sampled at the acknowledge edge.
- R7: During a read acknowledge, `data_o` carries the addressed lanes and zero elsewhere. In every cycle without a read acknowledge, `data_o` is zero.
- R8: A misaligned or reserved-size request in the window is acknowledged with the normal wait count, changes no memory and returns zero data. `err_o` goes high the cycle after that acknowledge and stays high until reset.
- R9: After reset, `ta_n_o` is high, `err_o` is low and every memory word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_n_i | input | 1 | Transfer start strobe, active low, one cycle |
| rd_wrn_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 26 | Byte address; bit 0 is the least significant |
| tsiz_i | input | 2 | Transfer size code |
| data_i | input | 32 | Write data from the master |
| data_o | output | 32 | Read data, zero outside a read acknowledge |
| ta_n_o | output | 1 | Transfer acknowledge, active low |
| err_o | output | 1 | Sticky misalignment flag |

## Verification
With the bench's settings (no read waits, two write waits), acknowledge for a read comes in the cycle right after the start edge. A write is acknowledged three cycles after that edge. The error flag follows one cycle after the acknowledge that causes it. The driver records the edge at which each start is sampled and pushes the expected data and wait count into a queue. The monitor samples on the falling edge: at every low acknowledge it pops an item and compares both data and elapsed cycles. The error flag and the return of acknowledge to high are checked one falling edge after the acknowledge, and unanswered out-of-window starts are watched for several cycles.

// File: rtl/sas_pkg.sv
// Shared constants and helpers for the strobed-start slave.
// Assumes a 32-bit bus split into four byte lanes, lane 0 most significant.
package sas_pkg;
    localparam int BUS_W  = 32;
    localparam int LANE_N = BUS_W / 8;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;

    // Expand a per-lane mask (bit k = lane k) into a bit mask on the bus.
    function automatic logic [BUS_W-1:0] lane_bits(input logic [LANE_N-1:0] m);
        logic [BUS_W-1:0] r;
        r = '0;
        for (int k = 0; k < LANE_N; k++) begin
            if (m[k]) r[BUS_W-1-8*k -: 8] = 8'hFF;
        end
        return r;
    endfunction
endpackage

// File: rtl/sas_decode.sv
// Address window hit, word index, lane mask and alignment check.
// Purely combinational; assumes addr bit 0 is the least significant byte address bit.
module sas_decode
    import sas_pkg::*;
#(
    parameter int               ADDR_W    = 26,
    parameter int               IDX_W     = 6,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 26'h0001000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        tsiz,
    output logic              hit,
    output logic              bad,
    output logic [IDX_W-1:0]  idx,
    output logic [LANE_N-1:0] mask
);
    localparam int TOP_LO = IDX_W + 2;

    logic [1:0] off;

    // Window compare and word index extraction.
    always_comb begin
        hit = (addr[ADDR_W-1:TOP_LO] == BASE_ADDR[ADDR_W-1:TOP_LO]);
        idx = addr[TOP_LO-1:2];
        off = addr[1:0];
    end

    // Lane selection and natural-alignment check per size code.
    always_comb begin
        unique case (tsiz)
            SZ_BYTE: begin
                bad  = 1'b0;
                mask = 4'b0001 << off;
            end
            SZ_HALF: begin
                bad  = off[0];
                mask = 4'b0011 << off;
            end
            SZ_WORD: begin
                bad  = (off != 2'b00);
                mask = 4'b1111;
            end
            default: begin
                bad  = 1'b1;
                mask = 4'b0000;
            end
        endcase
    end
endmodule

// File: rtl/sas_waitgen.sv
// Wait-state sequencer: one-cycle acknowledge pulse a fixed count after start.
// Assumes no new start is presented while busy or acknowledging.
module sas_waitgen #(
    parameter int RD_WAIT = 0,
    parameter int WR_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_rd,
    output logic ack,
    output logic idle
);
    localparam int MAX_W = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
    localparam int CNT_W = $clog2(MAX_W + 1) + 1;
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_WAIT);
    localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_WAIT);

    logic             busy_q;
    logic             ack_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load;

    // Wait count for the direction being started.
    always_comb load = is_rd ? RD_LD : WR_LD;

    // Count down wait states and raise the acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ack_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            if (start) begin
                if (load == '0) begin
                    ack_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    cnt_q  <= load - 1'b1;
                end
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    ack_q  <= 1'b1;
                    busy_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign ack  = ack_q;
    assign idle = !busy_q && !ack_q;
endmodule

// File: rtl/sas_store.sv
// Word array with per-lane write merge; reads are combinational.
// Assumes lane 0 occupies the most significant byte of a word.
module sas_store
    import sas_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter int IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_N-1:0] mask,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata
);
    logic [BUS_W-1:0] mem [MEM_WORDS];
    logic [BUS_W-1:0] merged;

    assign rdata = mem[idx];

    // Per lane: new byte where selected, old byte elsewhere.
    for (genvar g = 0; g < LANE_N; g++) begin : g_lane
        assign merged[BUS_W-1-8*g -: 8] = mask[g] ? wdata[BUS_W-1-8*g -: 8]
                                                  : rdata[BUS_W-1-8*g -: 8];
    end

    // Clear on reset, store merged word on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= merged;
        end
    end
endmodule

// File: rtl/strobe_ack_slave.sv
// Bus slave with one-cycle start strobe and one-cycle acknowledge.
// Captures the request at the start edge, waits a per-direction count,
// then acknowledges; misaligned requests set a sticky error and do nothing.
// Assumes the master holds address, direction and write data until acknowledge.
module strobe_ack_slave
    import sas_pkg::*;
#(
    parameter int                ADDR_W    = 26,
    parameter int                MEM_WORDS = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 26'h0001000,
    parameter int                RD_WAIT   = 0,
    parameter int                WR_WAIT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_n_i,
    input  logic              rd_wrn_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        tsiz_i,
    input  logic [BUS_W-1:0]  data_i,
    output logic [BUS_W-1:0]  data_o,
    output logic              ta_n_o,
    output logic              err_o
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic              dec_hit;
    logic              dec_bad;
    logic [IDX_W-1:0]  dec_idx;
    logic [LANE_N-1:0] dec_mask;

    logic              start_acc;
    logic              ack;
    logic              idle;
    logic              mem_we;
    logic [BUS_W-1:0]  rdata;

    logic              cap_rd;
    logic              cap_bad;
    logic [IDX_W-1:0]  cap_idx;
    logic [LANE_N-1:0] cap_mask;
    logic              err_q;

    sas_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .addr(addr_i),
        .tsiz(tsiz_i),
        .hit (dec_hit),
        .bad (dec_bad),
        .idx (dec_idx),
        .mask(dec_mask)
    );

    // Accept a start only when it targets this window and the slave is free.
    always_comb start_acc = !ts_n_i && dec_hit && idle;

    // Hold the request attributes for the life of the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_rd   <= 1'b1;
            cap_bad  <= 1'b0;
            cap_idx  <= '0;
            cap_mask <= '0;
        end else if (start_acc) begin
            cap_rd   <= rd_wrn_i;
            cap_bad  <= dec_bad;
            cap_idx  <= dec_idx;
            cap_mask <= dec_mask;
        end
    end

    sas_waitgen #(
        .RD_WAIT(RD_WAIT),
        .WR_WAIT(WR_WAIT)
    ) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_acc),
        .is_rd(rd_wrn_i),
        .ack  (ack),
        .idle (idle)
    );

    // Commit write only at the acknowledge edge of an aligned write.
    always_comb mem_we = ack && !cap_rd && !cap_bad;

    sas_store #(
        .MEM_WORDS(MEM_WORDS),
        .IDX_W    (IDX_W)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .idx  (cap_idx),
        .mask (cap_mask),
        .wdata(data_i),
        .rdata(rdata)
    );

    // Sticky error raised when a misaligned transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                err_q <= 1'b0;
        else if (ack && cap_bad)   err_q <= 1'b1;
    end

    // Drive addressed lanes only during an aligned read acknowledge.
    always_comb begin
        if (ack && cap_rd && !cap_bad) data_o = rdata & lane_bits(cap_mask);
        else                           data_o = '0;
    end

    assign ta_n_o = !ack;
    assign err_o  = err_q;
endmodule

// File: rtl/strobe_ack_slave_chk.sv
// Protocol checker bound to the slave: acknowledge shape, wait count,
// error stickiness and quiet read bus.
module strobe_ack_slave_chk #(
    parameter int RD_WAIT = 0,
    parameter int WR_WAIT = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ts_n_i,
    input logic        ta_n_o,
    input logic        err_o,
    input logic [31:0] data_o,
    input logic        start_acc,
    input logic        rd_wrn_i,
    input logic        cap_bad,
    input logic        mem_we
);
    logic        pend_q;
    logic        pend_rd_q;
    logic [15:0] wcnt_q;

    // Count cycles from an accepted start to its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_rd_q <= 1'b0;
            wcnt_q    <= '0;
        end else if (start_acc) begin
            pend_q    <= 1'b1;
            pend_rd_q <= rd_wrn_i;
            wcnt_q    <= '0;
        end else if (pend_q) begin
            if (!ta_n_o) pend_q <= 1'b0;
            else         wcnt_q <= wcnt_q + 1'b1;
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n_o |=> ta_n_o);                                              // R3
    AST_NO_ACK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_n_i |-> ta_n_o);                                              // R3
    AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ta_n_o && pend_q) |-> (wcnt_q == 16'(pend_rd_q ? RD_WAIT : WR_WAIT))); // R3
    AST_ACK_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n_o |-> pend_q);                                              // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);                                                 // R8
    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ta_n_o && cap_bad) |-> !mem_we);                                // R8
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ta_n_o |-> (data_o == 32'h0));                                    // R7
endmodule

bind strobe_ack_slave strobe_ack_slave_chk #(
    .RD_WAIT(RD_WAIT),
    .WR_WAIT(WR_WAIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ts_n_i   (ts_n_i),
    .ta_n_o   (ta_n_o),
    .err_o    (err_o),
    .data_o   (data_o),
    .start_acc(start_acc),
    .rd_wrn_i (rd_wrn_i),
    .cap_bad  (cap_bad),
    .mem_we   (mem_we)
);

// File: tb/sim_strobe_ack_slave.sv
`timescale 1ns/1ps
module sim_strobe_ack_slave;
    localparam int RDW = 0;
    localparam int WRW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts_n = 1'b1;
    logic        rd_wrn = 1'b1;
    logic [25:0] addr = '0;
    logic [1:0]  tsiz = 2'b00;
    logic [31:0] wdata = '0;
    logic [31:0] data_o;
    logic        ta_n_o;
    logic        err_o;

    always #4 clk = ~clk;

    strobe_ack_slave #(.RD_WAIT(RDW), .WR_WAIT(WRW)) u0 (
        .clk(clk), .rst_n(rst_n), .ts_n_i(ts_n), .rd_wrn_i(rd_wrn),
        .addr_i(addr), .tsiz_i(tsiz), .data_i(wdata),
        .data_o(data_o), .ta_n_o(ta_n_o), .err_o(err_o)
    );

    typedef struct {
        logic [31:0] data;
        int          waits;
        int          start;
        string       req;
    } item_t;

    item_t       sbq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          pops = 0;
    logic [31:0] model [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Lane bits for a size and offset, lane k at bits [31-8k -: 8].
    function automatic logic [31:0] lanes(input logic [1:0] sz, input logic [1:0] off);
        int n;
        logic [31:0] r;
        n = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
        r = '0;
        for (int k = 0; k < 4; k++)
            if (k >= off && k < off + n) r[31-8*k -: 8] = 8'hFF;
        return r;
    endfunction

    // Monitor: pop and compare at every acknowledge.
    always @(negedge clk) begin
        if (rst_n && !ta_n_o) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R2 unexpected ack", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(data_o == it.data, {it.req, " data"}, data_o, it.data);
                check((cyc - it.start) == it.waits, "R3 wait count",
                      32'(cyc - it.start), 32'(it.waits));
            end
            pops++;
        end
    end

    // Driver: one transfer, expectation pushed before start.
    task automatic xfer(input bit rd, input logic [25:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit scramble, input string req);
        bit          hit;
        bit          bad;
        logic [31:0] m;
        logic [5:0]  ix;
        item_t       it;
        int          target;
        hit = (a[25:8] == 18'h10);
        bad = (sz == 2'b11) || (sz == 2'b10 && a[0]) || (sz == 2'b00 && a[1:0] != 2'b00);
        m   = lanes(sz, a[1:0]);
        ix  = a[7:2];
        @(negedge clk);
        addr = a; rd_wrn = rd; tsiz = sz; ts_n = 1'b0; wdata = 32'h0;
        if (hit) begin
            it.data  = (rd && !bad) ? (model[ix] & m) : 32'h0;
            it.waits = rd ? RDW : WRW;
            it.start = cyc + 1;
            it.req   = req;
            sbq.push_back(it);
        end
        target = pops + 1;
        @(negedge clk);
        ts_n = 1'b1;
        if (!rd) wdata = wd;
        if (scramble) begin addr = a + 26'h4; tsiz = 2'b01; rd_wrn = ~rd; end
        if (hit) begin
            wait (pops == target);
            if (!rd && !bad) model[ix] = (model[ix] & ~m) | (wd & m);
            @(negedge clk);
            check(ta_n_o == 1'b1, "R3 single-cycle ack", {31'h0, ta_n_o}, 32'h1);
            if (bad) check(err_o == 1'b1, "R8 err after ack", {31'h0, err_o}, 32'h1);
        end else begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 6; i++) begin
                if (!ta_n_o) quiet = 1'b0;
                @(negedge clk);
            end
            check(quiet, "R2 no ack outside window", {31'h0, quiet}, 32'h1);
        end
        addr = '0; tsiz = 2'b00; rd_wrn = 1'b1; wdata = '0;
    endtask

    initial begin
        #200000;
        check(1'b0, "watchdog", 32'h0, 32'h1);
        summary();
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ta_n_o == 1'b1, "R9 ack idle", {31'h0, ta_n_o}, 32'h1);
        check(err_o == 1'b0, "R9 err clear", {31'h0, err_o}, 32'h0);
        check(data_o == 32'h0, "R9 bus quiet", data_o, 32'h0);
        xfer(1, 26'h1000, 2'b00, 0, 0, "R9 memory zero");
        xfer(1, 26'h10FC, 2'b00, 0, 0, "R9 memory zero top");

        xfer(0, 26'h1004, 2'b00, 32'h12345678, 0, "R6 word write");
        xfer(1, 26'h1004, 2'b00, 0, 0, "R7 word read");
        for (int k = 0; k < 4; k++)
            xfer(1, 26'h1004 + 26'(k), 2'b01, 0, 0, "R5 byte lane read");
        xfer(1, 26'h1004, 2'b10, 0, 0, "R7 upper half read");
        xfer(1, 26'h1006, 2'b10, 0, 0, "R7 lower half read");

        xfer(0, 26'h1009, 2'b01, 32'hFFAAFFFF, 0, "R6 byte write");
        xfer(1, 26'h1008, 2'b00, 0, 0, "R6 only lane 1 written");
        xfer(0, 26'h100A, 2'b10, 32'hEEEEBEEF, 0, "R6 half write");
        xfer(1, 26'h1008, 2'b00, 0, 0, "R6 half lanes merged");

        check(err_o == 1'b0, "R8 err low before misalign", {31'h0, err_o}, 32'h0);
        xfer(1, 26'h1005, 2'b10, 0, 0, "R8 misaligned half read zero");
        xfer(0, 26'h1006, 2'b00, 32'hDEADBEEF, 0, "R8 misaligned word write");
        xfer(0, 26'h1004, 2'b11, 32'hDEADBEEF, 0, "R4 reserved size write");
        xfer(0, 26'h1003, 2'b01, 32'h000000C3, 0, "R4 byte at odd offset");
        xfer(1, 26'h1004, 2'b00, 0, 0, "R8 memory unchanged");
        xfer(1, 26'h1000, 2'b00, 0, 0, "R4 byte offset 3 written");

        xfer(0, 26'h1104, 2'b00, 32'hCAFEF00D, 0, "R2 outside window");
        xfer(1, 26'h1004, 2'b00, 0, 0, "R2 aliased word unchanged");

        xfer(0, 26'h1010, 2'b00, 32'hA5A55A5A, 1, "R1 write with moving inputs");
        xfer(1, 26'h1010, 2'b00, 0, 0, "R1 original address written");
        xfer(1, 26'h1014, 2'b00, 0, 0, "R1 neighbour untouched");
        xfer(1, 26'h1010, 2'b00, 0, 1, "R1 read with moving inputs");

        xfer(0, 26'h10FC, 2'b00, 32'h0BADCAFE, 0, "R6 last word write");
        xfer(1, 26'h10FE, 2'b10, 0, 0, "R5 last word low half");

        check(err_o == 1'b1, "R8 err sticky", {31'h0, err_o}, 32'h1);
        check(sbq.size() == 0, "R3 all acks seen", 32'(sbq.size()), 32'h0);
        summary();
    end
endmodule